// File: doc/BRIEF.md
# Debug Exception Entry Sequencer

This block converts a software debug event into an abort-style exception entry. Events are only acted on while the core runs in monitor debug mode. Four event strobes can arrive: a hardware breakpoint, a breakpoint instruction, a vector catch and a watchpoint. Each one comes with the address of the cancelled instruction, the data fault address, the current status word and the vector base.

Instruction-side events go down the instruction-abort path. A watchpoint goes down the data-abort path. The block then produces, in one registered cycle, every register update for the entry:

- the debug status method-of-entry code;
- the fault status and address registers for the chosen side;
- the abort-mode saved status and link registers;
- the new status word;
- the new program counter.

A single-cycle done strobe marks each entry, and write enables tell the register file which fault registers to load. Two kinds of vector catch are dropped without an exception: a catch on the instruction-abort vector and a catch on the data-abort vector.

Top module: `dbg_entry_seq`

## Requirements
- R1: No entry happens (`entry_done_o`, `ifault_we_o` and `dfault_we_o` all stay low) while `monitor_en_i` is low, whatever events are present.
- R2: A vector catch whose `vcatch_kind_i` is 2'b01 (instruction-abort vector) or 2'b10 (data-abort vector) is ignored. With no other event in that cycle, no entry occurs and every data output holds its value. Kinds 2'b00 and 2'b11 do cause an entry.
- R3: Breakpoint, breakpoint-instruction and accepted vector-catch entries take the instruction path:
  - `ifault_we_o`=1 and `dfault_we_o`=0;
  - `ifsr_o`=5'b00010;
  - `ifar_o` = cancelled instruction address.
- R4: Watchpoint entries take the data path:
  - `dfault_we_o`=1 and `ifault_we_o`=0;
  - `dfsr_o`=5'b00010;
  - `far_o` = data fault address;
  - `wfar_o` = cancelled instruction address.
- R5: On every entry `spsr_abt_o` receives the status word as presented in the event cycle, before any change.
- R6: On every entry the new status word `psr_o` is built from the current one as follows. Bits [4:0]=5'b10111. Bit 5 (compact-instruction state) and bit 24 (bytecode state) are 0. Bit 7 (normal-interrupt mask) and bit 8 (imprecise-abort mask) are 1. All other bits are copied.
- R7: `lr_abt_o` is the cancelled instruction address plus 4 on the instruction path, and plus 8 on the data path.
- R8: `pc_o` is the vector base plus 0x0C on the instruction path, and plus 0x10 on the data path.
- R9: `moe_o` records the cause: 4'b0001 breakpoint, 4'b0011 breakpoint instruction, 4'b0101 vector catch, 4'b1010 watchpoint.
- R10: When several accepted events coincide, any instruction-side event beats a watchpoint. Among instruction-side events the order is breakpoint, then breakpoint instruction, then vector catch.
- R11: All updates appear together one clock after the event cycle.
  - `entry_done_o` pulses for exactly that cycle, together with the single matching write enable.
  - Data outputs hold between entries.
  - Synchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| monitor_en_i | input | 1 | Monitor debug mode selected |
| ev_bkpt_i | input | 1 | Breakpoint event strobe |
| ev_bkpt_insn_i | input | 1 | Breakpoint instruction event strobe |
| ev_vcatch_i | input | 1 | Vector catch event strobe |
| vcatch_kind_i | input | 2 | Caught vector: 01 instruction abort, 10 data abort, other values any other vector |
| ev_watch_i | input | 1 | Watchpoint event strobe |
| cancel_addr_i | input | ADDR_W | Address of the cancelled instruction |
| fault_addr_i | input | ADDR_W | Data address that hit the watchpoint |
| cur_psr_i | input | 32 | Current status word |
| vec_base_i | input | ADDR_W | Exception vector base |
| entry_done_o | output | 1 | One-cycle strobe per entry |
| ifault_we_o | output | 1 | Load instruction fault status and address |
| dfault_we_o | output | 1 | Load data fault status, fault address and watchpoint address |
| moe_o | output | 4 | Method-of-entry code |
| ifsr_o | output | 5 | Instruction fault status value |
| ifar_o | output | ADDR_W | Instruction fault address value |
| dfsr_o | output | 5 | Data fault status value |
| far_o | output | ADDR_W | Data fault address value |
| wfar_o | output | ADDR_W | Watchpoint fault address value |
| spsr_abt_o | output | 32 | Abort-mode saved status word |
| lr_abt_o | output | ADDR_W | Abort-mode link register value |
| psr_o | output | 32 | New status word |
| pc_o | output | ADDR_W | New program counter |

## Verification
A watchpoint and an instruction-side event can fall in the same cycle. This is provoked in three ways:

- a watchpoint together with a breakpoint;
- a watchpoint together with an accepted vector catch;
- a watchpoint together with a filtered vector catch.

The first two must produce an instruction-path entry with no data-fault write. The third must produce a plain data-path entry. Each of these outcomes is judged against the scoreboard model on the link offset, vector, method-of-entry code and which write enable fires. Random cycles that mix all strobes, vector-catch kinds and monitor mode repeat these collisions many more times.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  localparam int PSR_W  = 32;
  localparam int MOE_W  = 4;
  localparam int FSR_W  = 5;

  localparam logic [4:0] MODE_ABORT = 5'b10111;
  localparam int BIT_T = 5;
  localparam int BIT_I = 7;
  localparam int BIT_A = 8;
  localparam int BIT_J = 24;

  localparam logic [FSR_W-1:0] FSR_DEBUG = 5'b00010;

  localparam logic [MOE_W-1:0] MOE_BKPT   = 4'b0001;
  localparam logic [MOE_W-1:0] MOE_BKINSN = 4'b0011;
  localparam logic [MOE_W-1:0] MOE_VCATCH = 4'b0101;
  localparam logic [MOE_W-1:0] MOE_WATCH  = 4'b1010;

  localparam logic [1:0] VC_KIND_IABT = 2'b01;
  localparam logic [1:0] VC_KIND_DABT = 2'b10;

  typedef enum logic {
    PATH_INSN = 1'b0,
    PATH_DATA = 1'b1
  } path_e;
endpackage

// File: rtl/dbg_event_filter.sv
module dbg_event_filter
  import dbg_entry_pkg::*;
(
  input  logic             monitor_en,
  input  logic             ev_bkpt,
  input  logic             ev_bkpt_insn,
  input  logic             ev_vcatch,
  input  logic [1:0]       vcatch_kind,
  input  logic             ev_watch,
  output logic             take,
  output path_e            path,
  output logic [MOE_W-1:0] moe
);
  logic vc_accept;
  logic insn_hit;

  // Catches on either abort vector are dropped.
  assign vc_accept = ev_vcatch && (vcatch_kind != VC_KIND_IABT)
                               && (vcatch_kind != VC_KIND_DABT);
  assign insn_hit  = ev_bkpt || ev_bkpt_insn || vc_accept;

  always_comb begin
    take = monitor_en && (insn_hit || ev_watch);
    path = insn_hit ? PATH_INSN : PATH_DATA;
    if (ev_bkpt)           moe = MOE_BKPT;
    else if (ev_bkpt_insn) moe = MOE_BKINSN;
    else if (vc_accept)    moe = MOE_VCATCH;
    else                   moe = MOE_WATCH;
  end
endmodule

// File: rtl/dbg_entry_calc.sv
module dbg_entry_calc
  import dbg_entry_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int LR_OFS_INSN  = 4,
  parameter int LR_OFS_DATA  = 8,
  parameter int VEC_OFS_INSN = 12,
  parameter int VEC_OFS_DATA = 16
) (
  input  path_e             path,
  input  logic [ADDR_W-1:0] cancel_addr,
  input  logic [ADDR_W-1:0] vec_base,
  input  logic [PSR_W-1:0]  cur_psr,
  output logic [ADDR_W-1:0] lr_val,
  output logic [ADDR_W-1:0] pc_val,
  output logic [PSR_W-1:0]  psr_val
);
  localparam logic [ADDR_W-1:0] LR_I  = ADDR_W'(LR_OFS_INSN);
  localparam logic [ADDR_W-1:0] LR_D  = ADDR_W'(LR_OFS_DATA);
  localparam logic [ADDR_W-1:0] VEC_I = ADDR_W'(VEC_OFS_INSN);
  localparam logic [ADDR_W-1:0] VEC_D = ADDR_W'(VEC_OFS_DATA);

  always_comb begin
    lr_val = cancel_addr + ((path == PATH_INSN) ? LR_I : LR_D);
    pc_val = vec_base + ((path == PATH_INSN) ? VEC_I : VEC_D);
    psr_val        = cur_psr;
    psr_val[4:0]   = MODE_ABORT;
    psr_val[BIT_T] = 1'b0;
    psr_val[BIT_J] = 1'b0;
    psr_val[BIT_I] = 1'b1;
    psr_val[BIT_A] = 1'b1;
  end
endmodule

// File: rtl/dbg_entry_seq.sv
module dbg_entry_seq
  import dbg_entry_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              monitor_en_i,
  input  logic              ev_bkpt_i,
  input  logic              ev_bkpt_insn_i,
  input  logic              ev_vcatch_i,
  input  logic [1:0]        vcatch_kind_i,
  input  logic              ev_watch_i,
  input  logic [ADDR_W-1:0] cancel_addr_i,
  input  logic [ADDR_W-1:0] fault_addr_i,
  input  logic [31:0]       cur_psr_i,
  input  logic [ADDR_W-1:0] vec_base_i,
  output logic              entry_done_o,
  output logic              ifault_we_o,
  output logic              dfault_we_o,
  output logic [3:0]        moe_o,
  output logic [4:0]        ifsr_o,
  output logic [ADDR_W-1:0] ifar_o,
  output logic [4:0]        dfsr_o,
  output logic [ADDR_W-1:0] far_o,
  output logic [ADDR_W-1:0] wfar_o,
  output logic [31:0]       spsr_abt_o,
  output logic [ADDR_W-1:0] lr_abt_o,
  output logic [31:0]       psr_o,
  output logic [ADDR_W-1:0] pc_o
);
  logic             take;
  path_e            path;
  logic [MOE_W-1:0] moe_n;
  logic [ADDR_W-1:0] lr_n, pc_n;
  logic [PSR_W-1:0]  psr_n;

  dbg_event_filter u_filter (
    .monitor_en   (monitor_en_i),
    .ev_bkpt      (ev_bkpt_i),
    .ev_bkpt_insn (ev_bkpt_insn_i),
    .ev_vcatch    (ev_vcatch_i),
    .vcatch_kind  (vcatch_kind_i),
    .ev_watch     (ev_watch_i),
    .take         (take),
    .path         (path),
    .moe          (moe_n)
  );

  dbg_entry_calc #(.ADDR_W(ADDR_W)) u_calc (
    .path        (path),
    .cancel_addr (cancel_addr_i),
    .vec_base    (vec_base_i),
    .cur_psr     (cur_psr_i),
    .lr_val      (lr_n),
    .pc_val      (pc_n),
    .psr_val     (psr_n)
  );

  // Strobes: single-cycle, registered.
  always_ff @(posedge clk) begin
    if (rst) begin
      entry_done_o <= 1'b0;
      ifault_we_o  <= 1'b0;
      dfault_we_o  <= 1'b0;
    end else begin
      entry_done_o <= take;
      ifault_we_o  <= take && (path == PATH_INSN);
      dfault_we_o  <= take && (path == PATH_DATA);
    end
  end

  // Values common to both entry paths.
  always_ff @(posedge clk) begin
    if (rst) begin
      moe_o      <= '0;
      spsr_abt_o <= '0;
      lr_abt_o   <= '0;
      psr_o      <= '0;
      pc_o       <= '0;
    end else if (take) begin
      moe_o      <= moe_n;
      spsr_abt_o <= cur_psr_i;
      lr_abt_o   <= lr_n;
      psr_o      <= psr_n;
      pc_o       <= pc_n;
    end
  end

  // Side-specific fault registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      ifsr_o <= '0;
      ifar_o <= '0;
      dfsr_o <= '0;
      far_o  <= '0;
      wfar_o <= '0;
    end else if (take) begin
      if (path == PATH_INSN) begin
        ifsr_o <= FSR_DEBUG;
        ifar_o <= cancel_addr_i;
      end else begin
        dfsr_o <= FSR_DEBUG;
        far_o  <= fault_addr_i;
        wfar_o <= cancel_addr_i;
      end
    end
  end

  // Checks beside the logic they guard.
  assert_no_entry_off_mode_R1: assert property (@(posedge clk) disable iff (rst)
    !monitor_en_i |=> !entry_done_o && !ifault_we_o && !dfault_we_o);

  assert_abort_vc_dropped_R2: assert property (@(posedge clk) disable iff (rst)
    (ev_vcatch_i && (vcatch_kind_i == VC_KIND_IABT || vcatch_kind_i == VC_KIND_DABT)
     && !ev_bkpt_i && !ev_bkpt_insn_i && !ev_watch_i) |=> !entry_done_o);

  assert_one_path_R11: assert property (@(posedge clk) disable iff (rst)
    entry_done_o |-> $onehot({ifault_we_o, dfault_we_o}));

  assert_strobe_pairs_R11: assert property (@(posedge clk) disable iff (rst)
    (ifault_we_o || dfault_we_o) |-> entry_done_o);

  assert_spsr_capture_R5: assert property (@(posedge clk) disable iff (rst)
    entry_done_o |-> spsr_abt_o == $past(cur_psr_i));

  assert_abort_psr_R6: assert property (@(posedge clk) disable iff (rst)
    entry_done_o |-> (psr_o[4:0] == MODE_ABORT) && psr_o[BIT_I] && psr_o[BIT_A]
                     && !psr_o[BIT_T] && !psr_o[BIT_J]);

  assert_insn_link_R7: assert property (@(posedge clk) disable iff (rst)
    (monitor_en_i && (ev_bkpt_i || ev_bkpt_insn_i)) |=>
      ifault_we_o && (lr_abt_o == $past(cancel_addr_i) + ADDR_W'(4)));

  assert_watch_data_R4: assert property (@(posedge clk) disable iff (rst)
    (monitor_en_i && ev_watch_i && !ev_bkpt_i && !ev_bkpt_insn_i && !ev_vcatch_i) |=>
      dfault_we_o && (far_o == $past(fault_addr_i)) && (moe_o == MOE_WATCH));

  assert_watch_loses_R10: assert property (@(posedge clk) disable iff (rst)
    (monitor_en_i && ev_watch_i && ev_bkpt_i) |=> !dfault_we_o && (moe_o == MOE_BKPT));
endmodule

// File: tb/dbg_entry_seq_bench.sv
module dbg_entry_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 0, rst = 1;
  logic mon, eb, ebi, evc, ew;
  logic [1:0] vk;
  logic [AW-1:0] ca, fa, vb;
  logic [31:0] cpsr;
  logic done, iwe, dwe;
  logic [3:0] moe;
  logic [4:0] ifsr, dfsr;
  logic [AW-1:0] ifar, far, wfar, lr, pc;
  logic [31:0] spsr, psr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_entry_seq #(.ADDR_W(AW)) u_dbg_entry_seq (
    .clk(clk), .rst(rst), .monitor_en_i(mon), .ev_bkpt_i(eb), .ev_bkpt_insn_i(ebi),
    .ev_vcatch_i(evc), .vcatch_kind_i(vk), .ev_watch_i(ew), .cancel_addr_i(ca),
    .fault_addr_i(fa), .cur_psr_i(cpsr), .vec_base_i(vb), .entry_done_o(done),
    .ifault_we_o(iwe), .dfault_we_o(dwe), .moe_o(moe), .ifsr_o(ifsr), .ifar_o(ifar),
    .dfsr_o(dfsr), .far_o(far), .wfar_o(wfar), .spsr_abt_o(spsr), .lr_abt_o(lr),
    .psr_o(psr), .pc_o(pc));

  typedef struct {
    bit d, iw, dw;
    logic [3:0] moe;
    logic [4:0] ifsr, dfsr;
    logic [31:0] ifar, far, wfar, spsr, lr, psr, pc;
  } exp_t;

  exp_t q[$];
  exp_t held;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the model's prediction.
  task automatic drive(input bit m, input bit b, input bit bi, input bit v,
                       input logic [1:0] k, input bit w, input logic [31:0] c,
                       input logic [31:0] f, input logic [31:0] p, input logic [31:0] base);
    exp_t e;
    bit vacc, ins, tk;
    @(negedge clk);
    mon = m; eb = b; ebi = bi; evc = v; vk = k; ew = w;
    ca = c; fa = f; cpsr = p; vb = base;
    vacc = v && (k == 2'b00 || k == 2'b11);
    ins  = b || bi || vacc;
    tk   = m && (ins || w);
    e = held;
    e.d = tk; e.iw = tk && ins; e.dw = tk && !ins;
    if (tk) begin
      e.moe  = b ? 4'b0001 : bi ? 4'b0011 : vacc ? 4'b0101 : 4'b1010;
      e.spsr = p;
      e.psr  = (p & ~(32'h1F | (32'h1 << 5) | (32'h1 << 24))) | 32'h17 | (32'h1 << 7) | (32'h1 << 8);
      e.lr   = c + (ins ? 32'd4 : 32'd8);
      e.pc   = base + (ins ? 32'h0C : 32'h10);
      if (ins) begin
        e.ifsr = 5'b00010; e.ifar = c;
      end else begin
        e.dfsr = 5'b00010; e.far = f; e.wfar = c;
      end
    end
    held = e;
    q.push_back(e);
  endtask

  // Monitor: compares one prediction per clock, just after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(done == e.d, "R11", "entry_done", 32'(done), 32'(e.d));
        chk(iwe == e.iw, "R3", "ifault_we", 32'(iwe), 32'(e.iw));
        chk(dwe == e.dw, "R4", "dfault_we", 32'(dwe), 32'(e.dw));
        chk(moe == e.moe, "R9", "moe", 32'(moe), 32'(e.moe));
        chk(ifsr == e.ifsr && ifar == e.ifar, "R3", "ifar", ifar, e.ifar);
        chk(dfsr == e.dfsr && far == e.far && wfar == e.wfar, "R4", "far/wfar", far ^ wfar, e.far ^ e.wfar);
        chk(spsr == e.spsr, "R5", "spsr", spsr, e.spsr);
        chk(psr == e.psr, "R6", "psr", psr, e.psr);
        chk(lr == e.lr, "R7", "lr", lr, e.lr);
        chk(pc == e.pc, "R8", "pc", pc, e.pc);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    mon = 0; eb = 0; ebi = 0; evc = 0; vk = 0; ew = 0;
    ca = 0; fa = 0; cpsr = 0; vb = 0;
    held = '{default: '0};
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R11 reset state
    chk(!done && !iwe && !dwe, "R11", "reset strobes", {29'b0, done, iwe, dwe}, 32'd0);
    chk(lr == 0 && pc == 0 && psr == 0 && spsr == 0, "R11", "reset data", lr | pc | psr | spsr, 32'd0);
    // R3 R9 breakpoint, R6 with T and J set on entry
    drive(1, 1, 0, 0, 0, 0, 32'h0000_1000, 32'h0, 32'h0100_0030, 32'hFFFF_0000);
    drive(1, 0, 1, 0, 0, 0, 32'h0000_2000, 32'h0, 32'h6000_0010, 32'h0);
    // R2 accepted catches (kinds 00 and 11), then filtered kinds
    drive(1, 0, 0, 1, 2'b00, 0, 32'h0000_3000, 32'h0, 32'h0000_001F, 32'h0);
    drive(1, 0, 0, 1, 2'b11, 0, 32'h0000_3100, 32'h0, 32'h0000_001F, 32'h0);
    drive(1, 0, 0, 1, 2'b01, 0, 32'h0000_3200, 32'h0, 32'hAAAA_AAAA, 32'h1234_0000);
    drive(1, 0, 0, 1, 2'b10, 0, 32'h0000_3300, 32'h0, 32'h5555_5555, 32'h1234_0000);
    // R4 R7 R8 watchpoint
    drive(1, 0, 0, 0, 0, 1, 32'h0000_4000, 32'hDEAD_BEE0, 32'h8000_0013, 32'h0000_0100);
    // R10 collisions
    drive(1, 1, 0, 0, 0, 1, 32'h0000_5000, 32'hCAFE_0000, 32'h0000_0010, 32'h0);
    drive(1, 0, 0, 1, 2'b11, 1, 32'h0000_5100, 32'hCAFE_0004, 32'h0000_0010, 32'h0);
    drive(1, 0, 0, 1, 2'b01, 1, 32'h0000_5200, 32'hCAFE_0008, 32'h0000_0010, 32'h0);
    drive(1, 1, 1, 1, 2'b00, 0, 32'h0000_5300, 32'h0, 32'h0, 32'h0);
    drive(1, 0, 1, 1, 2'b00, 1, 32'h0000_5400, 32'h0, 32'h0, 32'h0);
    // R1 monitor mode off
    drive(0, 1, 1, 1, 2'b00, 1, 32'h0000_6000, 32'h1, 32'hFFFF_FFFF, 32'h0);
    drive(0, 0, 0, 0, 0, 1, 32'h0000_6100, 32'h2, 32'h0, 32'h0);
    // R11 idle hold
    drive(1, 0, 0, 0, 0, 0, 32'h0, 32'h0, 32'h0, 32'h0);
    // R11 address wrap for R7
    drive(1, 0, 0, 0, 0, 1, 32'hFFFF_FFFC, 32'h4, 32'h0, 32'hFFFF_FFF8);
    // mixed random traffic
    for (int i = 0; i < 400; i++)
      drive($urandom % 4 != 0, $urandom % 5 == 0, $urandom % 5 == 0, $urandom % 4 == 0,
            2'($urandom), $urandom % 3 == 0, $urandom, $urandom, $urandom, $urandom);
    drive(0, 0, 0, 0, 0, 0, 32'h0, 32'h0, 32'h0, 32'h0);
    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule